// File: doc/BRIEF.md
# Host-Controlled CPU Run/Halt/Step Controller

This block lets a host processor start, stop and single-step an embedded CPU core through one 8-bit control register. The host writes the register to request running, halting or a single step. The block drives run, halt and step-enable levels to the CPU sequencer. It takes back a one-cycle "instruction complete" strobe, and it uses that strobe to end a pending stop or a step. A halt is only honoured at an instruction boundary. The step request clears itself and always reads back as zero.

With no host attached, the CPU starts from reset on its own. The condition is that both host strobes are held low during reset. Execution then begins with the program counter cleared to zero. A host-requested start instead resumes at the current program counter.

The same register holds the interface-mode bits that tell the remote-access arbiter how the host is wired. There is one bit each for latched read, latched write and fast buffered write. The block decodes these bits into a write mode and a read mode. A decoded mode never changes while a remote access is in progress. All pins are plain levels or single-cycle strobes: there is no streamed data, so nothing here uses valid/ready or back-pressure.

Top module: `cpu_run_ctl`

## Requirements
- R1: A reset with either host strobe high leaves the controller halted, with the register reading 0x00, the write mode slow buffered (0) and the read mode buffered (0). In the cycle after a reset cycle, `pc_zero` is low.
- R2: A reset in which both `host_rd_n` and `host_wr_n` are low puts the controller in run. `pc_zero` is high for exactly the first cycle after the last reset cycle. The register still reads 0x00.
- R3: A write with bit 2 (start) set, made while halted, asserts `cpu_run` from the next cycle. `pc_zero` stays low, so execution resumes at the current program counter.
- R4: A write with bit 2 clear, made while running, does not stop the CPU at once. `cpu_run` stays high until `instr_done` is sampled. `cpu_halted` then rises in the next cycle.
- R5: A write with bit 6 (step) set and bit 2 clear, made while halted, raises `cpu_step` and `cpu_run` in the next cycle. Both stay high until `instr_done`. After that the controller halts, or runs if a later write has set bit 2 in the meantime.
- R6: The register reads back every bit as last written, except bit 6, which always reads 0. The other fields are: bit 7 and bits 1:0 are stored only, bit 5 is fast buffered write, bit 4 is latched read, bit 3 is latched write and bit 2 is start.
- R7: A write made while halted with both bit 2 and bit 6 set starts a normal run. `cpu_step` stays low.
- R8: Write-mode decode: latched write (2) when bit 3 is 1, whatever bit 5 holds. Otherwise fast buffered (1) when bit 5 is 1, and slow buffered (0) when bit 5 is 0. `rd_latched` equals bit 4. Code 3 never appears.
- R9: The decoded modes reload from the register only at clock edges where `access_busy` is low. A mode change written during an access therefore appears one cycle after the access ends.
- R10: A step request written while the CPU is running, stopping or stepping has no effect on `cpu_step`.
- R11: A write with bit 2 set while a stop is pending cancels the stop. The controller keeps running even when `instr_done` arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd_n | input | 1 | Host read strobe, active low; sampled only during reset |
| host_wr_n | input | 1 | Host write strobe, active low; sampled only during reset |
| cfg_wr | input | 1 | Register write enable, one cycle per write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (bit 6 always 0) |
| instr_done | input | 1 | CPU strobe: current instruction completed |
| access_busy | input | 1 | Remote access in progress; freezes mode outputs |
| cpu_run | output | 1 | CPU may execute (run, stop pending or step) |
| cpu_halted | output | 1 | Controller idle |
| cpu_step | output | 1 | Single-step in progress |
| pc_zero | output | 1 | One-cycle request to clear the program counter |
| wr_mode | output | 2 | 0 slow buffered, 1 fast buffered, 2 latched write |
| rd_latched | output | 1 | 1 latched read, 0 buffered read |

## Verification
A write or an `instr_done` strobe sampled at one edge shows up in `cpu_run`, `cpu_halted`, `cpu_step` and `cfg_rdata` right after that edge. `pc_zero` is due right after the last reset edge. A mode change passes through two registers, so it needs one edge with the register updated and a further edge with `access_busy` low. A behavioural model in the bench updates at each rising edge from the same stimulus. Every output is compared against it at the following falling edge, so each result is taken in the cycle it is due, and the stimulus is driven only at falling edges.

// File: rtl/cpu_run_pkg.sv
package cpu_run_pkg;
  localparam int CTL_W   = 8;
  localparam int B_BIS   = 7;
  localparam int B_STEP  = 6;
  localparam int B_FBW   = 5;
  localparam int B_LRD   = 4;
  localparam int B_LWR   = 3;
  localparam int B_START = 2;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RUN       = 2'd1,
    ST_STOP_PEND = 2'd2,
    ST_STEP      = 2'd3
  } run_state_t;

  typedef enum logic [1:0] {
    WM_SLOW  = 2'd0,
    WM_FAST  = 2'd1,
    WM_LATCH = 2'd2
  } wr_mode_t;
endpackage

// File: rtl/run_ctl_reg.sv
module run_ctl_reg
  import cpu_run_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         start_q,
  output logic         fbw_q,
  output logic         lrd_q,
  output logic         lwr_q
);
  localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << B_STEP);

  logic [W-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      bits_q <= '0;
    else if (wr_en)  bits_q <= wdata & KEEP_MASK;
  end

  assign rdata   = bits_q;
  assign start_q = bits_q[B_START];
  assign fbw_q   = bits_q[B_FBW];
  assign lrd_q   = bits_q[B_LRD];
  assign lwr_q   = bits_q[B_LWR];
endmodule

// File: rtl/run_ctl_fsm.sv
module run_ctl_fsm
  import cpu_run_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_req,
  input  logic       wr_en,
  input  logic       wr_start,
  input  logic       wr_step,
  input  logic       start_q,
  input  logic       instr_done,
  output run_state_t state,
  output logic       pc_zero
);
  run_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (wr_en && wr_start)     nxt = ST_RUN;
        else if (wr_en && wr_step) nxt = ST_STEP;
      end
      ST_RUN: begin
        if (wr_en && !wr_start)    nxt = ST_STOP_PEND;
      end
      ST_STOP_PEND: begin
        if (wr_en && wr_start)     nxt = ST_RUN;
        else if (instr_done)       nxt = ST_IDLE;
      end
      ST_STEP: begin
        if (instr_done)            nxt = start_q ? ST_RUN : ST_IDLE;
      end
      default:                     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= boot_req ? ST_RUN : ST_IDLE;
      pc_zero <= boot_req;
    end else begin
      state   <= nxt;
      pc_zero <= 1'b0;
    end
  end
endmodule

// File: rtl/run_ctl_mode.sv
module run_ctl_mode
  import cpu_run_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy,
  input  logic     fbw,
  input  logic     lrd,
  input  logic     lwr,
  output wr_mode_t wr_mode,
  output logic     rd_latched
);
  wr_mode_t dec;

  always_comb begin
    if (lwr)      dec = WM_LATCH;
    else if (fbw) dec = WM_FAST;
    else          dec = WM_SLOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_mode    <= WM_SLOW;
      rd_latched <= 1'b0;
    end else if (!busy) begin
      wr_mode    <= dec;
      rd_latched <= lrd;
    end
  end
endmodule

// File: rtl/cpu_run_ctl.sv
module cpu_run_ctl
  import cpu_run_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             cfg_wr,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] cfg_rdata,
  input  logic             instr_done,
  input  logic             access_busy,
  output logic             cpu_run,
  output logic             cpu_halted,
  output logic             cpu_step,
  output logic             pc_zero,
  output logic [1:0]       wr_mode,
  output logic             rd_latched
);
  logic       start_q, fbw_q, lrd_q, lwr_q;
  run_state_t state;
  wr_mode_t   mode_w;

  run_ctl_reg #(.W(CTL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .start_q(start_q), .fbw_q(fbw_q),
    .lrd_q(lrd_q), .lwr_q(lwr_q)
  );

  run_ctl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .boot_req(!host_rd_n && !host_wr_n),
    .wr_en(cfg_wr), .wr_start(cfg_wdata[B_START]),
    .wr_step(cfg_wdata[B_STEP]), .start_q(start_q),
    .instr_done(instr_done), .state(state), .pc_zero(pc_zero)
  );

  run_ctl_mode u_mode (
    .clk(clk), .rst_n(rst_n), .busy(access_busy),
    .fbw(fbw_q), .lrd(lrd_q), .lwr(lwr_q),
    .wr_mode(mode_w), .rd_latched(rd_latched)
  );

  assign wr_mode    = mode_w;
  assign cpu_run    = (state != ST_IDLE);
  assign cpu_halted = (state == ST_IDLE);
  assign cpu_step   = (state == ST_STEP);
endmodule

// File: rtl/cpu_run_ctl_chk.sv
module cpu_run_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       wr_start,
  input logic       instr_done,
  input logic       access_busy,
  input logic       ss_rd,
  input logic       cpu_run,
  input logic       cpu_halted,
  input logic       cpu_step,
  input logic       pc_zero,
  input logic [1:0] wr_mode
);
  // R6
  ss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rd);

  // R4
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !instr_done) |=> cpu_run);

  // R5
  step_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_step && instr_done) |=> !cpu_step);

  // R7
  start_beats_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halted && cfg_wr && wr_start) |=> (cpu_run && !cpu_step));

  // R10
  no_step_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !cpu_step) |=> !cpu_step);

  // R8
  mode_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode != 2'd3);

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_busy |=> $stable(wr_mode));

  // R2
  pc_zero_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_zero |-> (cpu_run && !cpu_step));

  // R1
  halt_xor_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halted != cpu_run);
endmodule

bind cpu_run_ctl cpu_run_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wr_start(cfg_wdata[2]),
  .instr_done(instr_done), .access_busy(access_busy), .ss_rd(cfg_rdata[6]),
  .cpu_run(cpu_run), .cpu_halted(cpu_halted), .cpu_step(cpu_step),
  .pc_zero(pc_zero), .wr_mode(wr_mode)
);

// File: tb/cpu_run_ctl_test.sv
module cpu_run_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       instr_done = 1'b0, access_busy = 1'b0;
  logic       cpu_run, cpu_halted, cpu_step, pc_zero, rd_latched;
  logic [1:0] wr_mode;

  int total = 0, bad = 0, cyc = 0;
  bit done_flag = 0;

  // model: 0 idle, 1 run, 2 stop pending, 3 step
  int m_st = 0, m_reg = 0, m_wm = 0, m_rl = 0, m_pcz = 0;

  always #5 clk = ~clk;

  cpu_run_ctl uut (
    .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .instr_done(instr_done), .access_busy(access_busy),
    .cpu_run(cpu_run), .cpu_halted(cpu_halted), .cpu_step(cpu_step),
    .pc_zero(pc_zero), .wr_mode(wr_mode), .rd_latched(rd_latched)
  );

  always @(posedge clk) begin
    int ns;
    if (!rst_n) begin
      m_reg = 0; m_wm = 0; m_rl = 0;
      m_pcz = (!host_rd_n && !host_wr_n) ? 1 : 0;
      m_st  = m_pcz;
    end else begin
      ns = m_st;
      if (m_st == 0) begin
        if (cfg_wr && cfg_wdata[2]) ns = 1;
        else if (cfg_wr && cfg_wdata[6]) ns = 3;
      end else if (m_st == 1) begin
        if (cfg_wr && !cfg_wdata[2]) ns = 2;
      end else if (m_st == 2) begin
        if (cfg_wr && cfg_wdata[2]) ns = 1;
        else if (instr_done) ns = 0;
      end else begin
        if (instr_done) ns = ((m_reg >> 2) & 1) ? 1 : 0;
      end
      m_st = ns;
      m_pcz = 0;
      if (!access_busy) begin
        m_wm = ((m_reg >> 3) & 1) ? 2 : (((m_reg >> 5) & 1) ? 1 : 0);
        m_rl = (m_reg >> 4) & 1;
      end
      if (cfg_wr) m_reg = int'(cfg_wdata) & 'hBF;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 2) begin
      chk("R1 R3 R4 R5 R7 R11 cpu_run", int'(cpu_run), (m_st != 0) ? 1 : 0);
      chk("R1 R4 cpu_halted", int'(cpu_halted), (m_st == 0) ? 1 : 0);
      chk("R5 R7 R10 cpu_step", int'(cpu_step), (m_st == 3) ? 1 : 0);
      chk("R1 R2 R3 pc_zero", int'(pc_zero), m_pcz);
      chk("R1 R8 R9 wr_mode", int'(wr_mode), m_wm);
      chk("R8 R9 rd_latched", int'(rd_latched), m_rl);
      chk("R1 R6 cfg_rdata", int'(cfg_rdata), m_reg);
    end
    if (cyc > 100000 && !done_flag) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic done_pulse();
    instr_done = 1'b1; tick(1); instr_done = 1'b0;
  endtask

  task automatic do_reset(input logic boot);
    rst_n = 1'b0; host_rd_n = !boot; host_wr_n = !boot;
    tick(2);
    rst_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    tick(1);
  endtask

  initial begin
    @(negedge clk);
    // R1: plain reset
    do_reset(1'b0);
    tick(2);
    // R3: host start, R4: deferred stop
    wr(8'h04); tick(3);
    wr(8'h00); tick(3);
    done_pulse(); tick(2);
    // R5: single step, R6 readback of step bit
    wr(8'h40); tick(3);
    done_pulse(); tick(2);
    // R5: start set during step -> run after step
    wr(8'h40); wr(8'h04); tick(1); done_pulse(); tick(2);
    // R10: step request while running ignored
    wr(8'h44); wr(8'h40); tick(2);
    // R11: cancel a pending stop, same cycle as instr_done
    cfg_wr = 1'b1; cfg_wdata = 8'h04; instr_done = 1'b1; tick(1);
    cfg_wr = 1'b0; instr_done = 1'b0; tick(2);
    wr(8'h00); done_pulse(); tick(2);
    // R7: start and step together
    wr(8'h44); tick(2); wr(8'h00); done_pulse(); tick(2);
    // R8: mode decode patterns
    wr(8'h20); tick(3);
    wr(8'h28); tick(3);
    wr(8'h10); tick(3);
    wr(8'hB3); tick(3);
    // R9: mode change during a busy access
    access_busy = 1'b1; wr(8'h08); tick(4);
    access_busy = 1'b0; tick(3);
    // R2: host-less boot start
    do_reset(1'b1);
    tick(3);
    wr(8'h00); done_pulse(); tick(2);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      cfg_wr      = ($urandom_range(0, 5) == 0);
      cfg_wdata   = 8'($urandom);
      instr_done  = ($urandom_range(0, 3) == 0);
      access_busy = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 400) == 0) begin
        cfg_wr = 1'b0; instr_done = 1'b0;
        do_reset(1'($urandom));
      end else begin
        tick(1);
      end
    end
    cfg_wr = 1'b0; instr_done = 1'b0; access_busy = 1'b0;
    tick(2);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule